// File: doc/BRIEF.md
# Core Idle State Entry Sequencer

This block steps one processor core between the running state and three idle depths. The shallowest idle depth only gates the clock. The middle depth first empties the core's private caches into the shared cache and then gates the clock. The deepest depth copies the architectural state into a retention memory and then switches the core's supply off. Each of these actions is a request/done handshake with an outside engine: the cache-flush engine, the state save/restore engine and the power-switch controller. Each request is held high until the engine returns a one-cycle done pulse.

An idle request can come from either of two sources: a legacy I/O-read trigger or a wait-with-hint command. Both use the same depth code. A wake input returns the core to running. From the deepest depth, the return path is power-up first, then state restore, then run. A wake that arrives while an entry handshake is still in progress is remembered. The current handshake always finishes, and only then does the core head back to running. A resident-state code tells the package-level controller which stable state the core is in.

Top module: `core_idle_seq`

## Requirements
- R1: After reset the core is running. `resident` is 0, `clk_en` is 1 and every handshake request is 0.
- R2: Depth code 0 selects the clock-gated idle, 1 selects the flushed idle and 2 selects the power-gated idle. Both request sources use the same codes and produce the same result. Code 3 counts as no request. If both sources hold a valid code in the same cycle, the I/O-read source wins.
- R3: A clock-gated idle request stops the clock with no handshake and sets `resident` to 1 on the next cycle. `wake` brings the core back to `resident` 0 with `clk_en` 1 one cycle later.
- R4: A flushed idle request raises `flush_req` with the clock still running. `flush_req` is held until `flush_done`. Only after that does `clk_en` fall and `resident` become 3.
- R5: In the flushed idle state only `wake` causes an exit. New idle requests and stray done pulses leave `resident` at 3 and all requests low.
- R6: A power-gated idle request holds `save_req` (clock on) until `save_done`. It then holds `pwr_off_req` (clock off) until `pwr_off_done`, and only then does `resident` become 6.
- R7: A wake from the power-gated idle holds `pwr_on_req` (clock off) until `pwr_on_done`. It then holds `restore_req` (clock on) until `restore_done`, and then the core runs.
- R8: A `wake` seen during the flush or the save is latched. The handshake in progress completes and the core returns directly to running without entering the deep state. A `wake` seen while power is being removed is also latched: the core reaches `resident` 6 and starts power-up on the next cycle.
- R9: `resident` is encoded 0, 1, 3 or 6. It changes only when a stable state is reached and holds its previous value through every handshake step.
- R10: Idle requests are ignored in every state except running.
- R11: At most one handshake request is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req_vld | input | 1 | Idle request from the legacy I/O-read trigger |
| io_req_lvl | input | 2 | Depth code for the I/O-read request |
| mw_req_vld | input | 1 | Idle request from the wait-with-hint command |
| mw_req_hint | input | 2 | Depth code for the wait-with-hint request |
| wake | input | 1 | Wake event |
| flush_req | output | 1 | Flush private caches into the shared cache |
| flush_done | input | 1 | Flush complete pulse |
| clk_en | output | 1 | Core clock enable |
| save_req | output | 1 | Save state into the retention memory |
| save_done | input | 1 | Save complete pulse |
| pwr_off_req | output | 1 | Switch the core supply off |
| pwr_off_done | input | 1 | Supply off pulse |
| pwr_on_req | output | 1 | Switch the core supply on |
| pwr_on_done | input | 1 | Supply on pulse |
| restore_req | output | 1 | Restore state from the retention memory |
| restore_done | input | 1 | Restore complete pulse |
| resident | output | 3 | Stable resident state code |

## Verification
The assertions check, on every cycle, the ordering rules that hold regardless of the stimulus. Each handshake request is held until its done pulse arrives. At most one request is active at a time. Restore only follows power-up. The flushed idle state is left only on `wake`. The clock stays gated while `resident` reports the clock-gated or flushed idle. Only the bench's scenarios can show the end-to-end behaviour: the depth decoding for both sources and the priority between them, the exact cycles at which `resident` moves, and the latched-wake paths that finish a handshake and then return to running.

// File: rtl/cidle_pkg.sv
package cidle_pkg;

    localparam int LVL_W = 2;
    localparam int RES_W = 3;

    typedef enum logic [3:0] {
        ST_ACTIVE,
        ST_C1,
        ST_FLUSH,
        ST_C3,
        ST_SAVE,
        ST_PWR_OFF,
        ST_C6,
        ST_PWR_ON,
        ST_RESTORE
    } cstate_e;

    typedef enum logic [LVL_W-1:0] {
        DEPTH_C1  = 2'd0,
        DEPTH_C3  = 2'd1,
        DEPTH_C6  = 2'd2,
        DEPTH_BAD = 2'd3
    } depth_e;

    localparam logic [RES_W-1:0] RES_C0 = 3'd0;
    localparam logic [RES_W-1:0] RES_C1 = 3'd1;
    localparam logic [RES_W-1:0] RES_C3 = 3'd3;
    localparam logic [RES_W-1:0] RES_C6 = 3'd6;

    typedef struct packed {
        cstate_e st;
        logic    pend;
    } fsm_s;

    function automatic logic is_stable(cstate_e s);
        return (s == ST_ACTIVE) || (s == ST_C1) || (s == ST_C3) || (s == ST_C6);
    endfunction

    function automatic logic [RES_W-1:0] res_code(cstate_e s);
        case (s)
            ST_C1:   return RES_C1;
            ST_C3:   return RES_C3;
            ST_C6:   return RES_C6;
            default: return RES_C0;
        endcase
    endfunction

endpackage

// File: rtl/cidle_req_arb.sv
module cidle_req_arb
    import cidle_pkg::*;
#(
    parameter bit IO_FIRST = 1'b1
) (
    input  logic             io_vld,
    input  logic [LVL_W-1:0] io_lvl,
    input  logic             mw_vld,
    input  logic [LVL_W-1:0] mw_lvl,
    output logic             req_vld,
    output depth_e           req_depth
);

    logic io_ok;
    logic mw_ok;
    logic sel_io;

    assign io_ok = io_vld && (depth_e'(io_lvl) != DEPTH_BAD);
    assign mw_ok = mw_vld && (depth_e'(mw_lvl) != DEPTH_BAD);

    generate
        if (IO_FIRST) begin : g_io_first
            assign sel_io = io_ok;
        end else begin : g_mw_first
            assign sel_io = io_ok && !mw_ok;
        end
    endgenerate

    assign req_vld   = io_ok || mw_ok;
    assign req_depth = sel_io ? depth_e'(io_lvl) : depth_e'(mw_lvl);

    always_comb begin
        assert (!req_vld || req_depth != DEPTH_BAD)
            else $error("p_arb_no_bad_depth_r2");
    end

endmodule

// File: rtl/cidle_seq_fsm.sv
module cidle_seq_fsm
    import cidle_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_vld,
    input  depth_e  req_depth,
    input  logic    wake,
    input  logic    flush_done,
    input  logic    save_done,
    input  logic    pwr_off_done,
    input  logic    pwr_on_done,
    input  logic    restore_done,
    output logic    flush_req,
    output logic    save_req,
    output logic    pwr_off_req,
    output logic    pwr_on_req,
    output logic    restore_req,
    output logic    clk_en,
    output cstate_e st_nxt
);

    fsm_s fsm_d;
    fsm_s fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            ST_ACTIVE: begin
                fsm_d.pend = 1'b0;
                if (req_vld) begin
                    case (req_depth)
                        DEPTH_C1: fsm_d.st = ST_C1;
                        DEPTH_C3: fsm_d.st = ST_FLUSH;
                        DEPTH_C6: fsm_d.st = ST_SAVE;
                        default:  fsm_d.st = ST_ACTIVE;
                    endcase
                end
            end
            ST_C1, ST_C3: begin
                if (wake) fsm_d.st = ST_ACTIVE;
            end
            ST_FLUSH: begin
                if (wake) fsm_d.pend = 1'b1;
                if (flush_done)
                    fsm_d.st = (fsm_q.pend || wake) ? ST_ACTIVE : ST_C3;
            end
            ST_SAVE: begin
                if (wake) fsm_d.pend = 1'b1;
                if (save_done)
                    fsm_d.st = (fsm_q.pend || wake) ? ST_ACTIVE : ST_PWR_OFF;
            end
            ST_PWR_OFF: begin
                if (wake) fsm_d.pend = 1'b1;
                if (pwr_off_done) fsm_d.st = ST_C6;
            end
            ST_C6: begin
                if (wake || fsm_q.pend) begin
                    fsm_d.st   = ST_PWR_ON;
                    fsm_d.pend = 1'b0;
                end
            end
            ST_PWR_ON: begin
                if (pwr_on_done) fsm_d.st = ST_RESTORE;
            end
            ST_RESTORE: begin
                if (restore_done) fsm_d.st = ST_ACTIVE;
            end
            default: begin
                fsm_d.st   = ST_ACTIVE;
                fsm_d.pend = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st   <= ST_ACTIVE;
            fsm_q.pend <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign flush_req   = (fsm_q.st == ST_FLUSH);
    assign save_req    = (fsm_q.st == ST_SAVE);
    assign pwr_off_req = (fsm_q.st == ST_PWR_OFF);
    assign pwr_on_req  = (fsm_q.st == ST_PWR_ON);
    assign restore_req = (fsm_q.st == ST_RESTORE);
    assign clk_en      = (fsm_q.st == ST_ACTIVE) || (fsm_q.st == ST_FLUSH) ||
                         (fsm_q.st == ST_SAVE)   || (fsm_q.st == ST_RESTORE);
    assign st_nxt      = fsm_d.st;

    p_flush_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_done) |=> flush_req);

    p_save_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !save_done) |=> save_req);

    p_pwroff_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_off_req && !pwr_off_done) |=> pwr_off_req);

    p_pwron_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on_req && !pwr_on_done) |=> pwr_on_req);

    p_restore_after_pwron_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on_req && pwr_on_done) |=> restore_req);

    p_c3_wake_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_C3 && !wake) |=> (fsm_q.st == ST_C3));

    p_one_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_req, save_req, pwr_off_req, pwr_on_req, restore_req}));

endmodule

// File: rtl/cidle_res_track.sv
module cidle_res_track
    import cidle_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cstate_e          st_nxt,
    output logic [RES_W-1:0] resident
);

    logic [RES_W-1:0] res_d;
    logic [RES_W-1:0] res_q;

    always_comb begin
        res_d = res_q;
        if (is_stable(st_nxt)) res_d = res_code(st_nxt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= RES_C0;
        else        res_q <= res_d;
    end

    assign resident = res_q;

    p_res_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_q == RES_C0) || (res_q == RES_C1) || (res_q == RES_C3) || (res_q == RES_C6));

endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
    import cidle_pkg::*;
#(
    parameter bit IO_FIRST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_req_vld,
    input  logic [LVL_W-1:0] io_req_lvl,
    input  logic             mw_req_vld,
    input  logic [LVL_W-1:0] mw_req_hint,
    input  logic             wake,
    output logic             flush_req,
    input  logic             flush_done,
    output logic             clk_en,
    output logic             save_req,
    input  logic             save_done,
    output logic             pwr_off_req,
    input  logic             pwr_off_done,
    output logic             pwr_on_req,
    input  logic             pwr_on_done,
    output logic             restore_req,
    input  logic             restore_done,
    output logic [RES_W-1:0] resident
);

    logic    req_vld;
    depth_e  req_depth;
    cstate_e st_nxt;

    cidle_req_arb #(.IO_FIRST(IO_FIRST)) i_arb (
        .io_vld    (io_req_vld),
        .io_lvl    (io_req_lvl),
        .mw_vld    (mw_req_vld),
        .mw_lvl    (mw_req_hint),
        .req_vld   (req_vld),
        .req_depth (req_depth)
    );

    cidle_seq_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_vld      (req_vld),
        .req_depth    (req_depth),
        .wake         (wake),
        .flush_done   (flush_done),
        .save_done    (save_done),
        .pwr_off_done (pwr_off_done),
        .pwr_on_done  (pwr_on_done),
        .restore_done (restore_done),
        .flush_req    (flush_req),
        .save_req     (save_req),
        .pwr_off_req  (pwr_off_req),
        .pwr_on_req   (pwr_on_req),
        .restore_req  (restore_req),
        .clk_en       (clk_en),
        .st_nxt       (st_nxt)
    );

    cidle_res_track i_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_nxt   (st_nxt),
        .resident (resident)
    );

    p_gated_in_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((resident == RES_C1) || (resident == RES_C3)) |-> !clk_en);

    p_c6_unpowered_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resident == RES_C6 && !restore_req) |-> !clk_en);

endmodule

// File: tb/test_core_idle_seq.sv
module test_core_idle_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_req_vld = 1'b0;
    logic [1:0] io_req_lvl = 2'd0;
    logic       mw_req_vld = 1'b0;
    logic [1:0] mw_req_hint = 2'd0;
    logic       wake = 1'b0;
    logic       flush_req, clk_en, save_req, pwr_off_req, pwr_on_req, restore_req;
    logic       flush_done = 1'b0;
    logic       save_done = 1'b0;
    logic       pwr_off_done = 1'b0;
    logic       pwr_on_done = 1'b0;
    logic       restore_done = 1'b0;
    logic [2:0] resident;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    core_idle_seq i_core_idle_seq (
        .clk(clk), .rst_n(rst_n),
        .io_req_vld(io_req_vld), .io_req_lvl(io_req_lvl),
        .mw_req_vld(mw_req_vld), .mw_req_hint(mw_req_hint),
        .wake(wake),
        .flush_req(flush_req), .flush_done(flush_done),
        .clk_en(clk_en),
        .save_req(save_req), .save_done(save_done),
        .pwr_off_req(pwr_off_req), .pwr_off_done(pwr_off_done),
        .pwr_on_req(pwr_on_req), .pwr_on_done(pwr_on_done),
        .restore_req(restore_req), .restore_done(restore_done),
        .resident(resident)
    );

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int reqs();
        return {27'd0, flush_req, save_req, pwr_off_req, pwr_on_req, restore_req};
    endfunction

    task automatic wake_up();
        wake = 1'b1; step(); wake = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "resident", resident, 0);
        chk("R1", "clk_en", clk_en, 1);
        chk("R1", "requests", reqs(), 0);
    endtask

    task automatic t_c1(bit use_io);
        if (use_io) begin io_req_vld = 1'b1; io_req_lvl = 2'd0; end
        else begin mw_req_vld = 1'b1; mw_req_hint = 2'd0; end
        step();
        io_req_vld = 1'b0; mw_req_vld = 1'b0;
        chk("R3", "c1 resident", resident, 1);
        chk("R2", "c1 clk_en", clk_en, 0);
        chk("R3", "c1 requests", reqs(), 0);
        step(3);
        chk("R3", "c1 hold", resident, 1);
        wake_up();
        chk("R3", "c1 exit resident", resident, 0);
        chk("R3", "c1 exit clk_en", clk_en, 1);
    endtask

    task automatic t_bad_code();
        io_req_vld = 1'b1; io_req_lvl = 2'd3;
        mw_req_vld = 1'b1; mw_req_hint = 2'd3;
        step(2);
        io_req_vld = 1'b0; mw_req_vld = 1'b0;
        chk("R2", "bad code resident", resident, 0);
        chk("R2", "bad code clk_en", clk_en, 1);
        chk("R2", "bad code requests", reqs(), 0);
    endtask

    task automatic t_prio();
        io_req_vld = 1'b1; io_req_lvl = 2'd0;
        mw_req_vld = 1'b1; mw_req_hint = 2'd1;
        step();
        io_req_vld = 1'b0; mw_req_vld = 1'b0;
        chk("R2", "priority resident", resident, 1);
        chk("R2", "priority flush", flush_req, 0);
        wake_up();
        // invalid I/O code lets the wait source through
        io_req_vld = 1'b1; io_req_lvl = 2'd3;
        mw_req_vld = 1'b1; mw_req_hint = 2'd0;
        step();
        io_req_vld = 1'b0; mw_req_vld = 1'b0;
        chk("R2", "bad io falls to wait", resident, 1);
        wake_up();
    endtask

    task automatic t_c3(bit use_io);
        if (use_io) begin io_req_vld = 1'b1; io_req_lvl = 2'd1; end
        else begin mw_req_vld = 1'b1; mw_req_hint = 2'd1; end
        step();
        io_req_vld = 1'b0; mw_req_vld = 1'b0;
        chk("R4", "flush_req", flush_req, 1);
        chk("R4", "clk on in flush", clk_en, 1);
        chk("R9", "resident in flush", resident, 0);
        step(4);
        chk("R4", "flush held", flush_req, 1);
        flush_done = 1'b1; step(); flush_done = 1'b0;
        chk("R4", "c3 resident", resident, 3);
        chk("R4", "c3 clk_en", clk_en, 0);
        chk("R4", "c3 requests", reqs(), 0);
        io_req_vld = 1'b1; io_req_lvl = 2'd2;
        flush_done = 1'b1; save_done = 1'b1;
        step(2);
        io_req_vld = 1'b0; flush_done = 1'b0; save_done = 1'b0;
        chk("R5", "c3 ignores stimulus", resident, 3);
        chk("R10", "c3 no new request", reqs(), 0);
        wake_up();
        chk("R5", "c3 exit", resident, 0);
        chk("R5", "c3 exit clk", clk_en, 1);
    endtask

    task automatic t_c6();
        mw_req_vld = 1'b1; mw_req_hint = 2'd2;
        step();
        mw_req_vld = 1'b0;
        chk("R6", "save_req", save_req, 1);
        chk("R6", "clk on in save", clk_en, 1);
        step(3);
        chk("R6", "save held", save_req, 1);
        io_req_vld = 1'b1; io_req_lvl = 2'd0;
        save_done = 1'b1; step(); save_done = 1'b0; io_req_vld = 1'b0;
        chk("R6", "pwr_off_req", pwr_off_req, 1);
        chk("R6", "clk off in pwr_off", clk_en, 0);
        chk("R9", "resident in pwr_off", resident, 0);
        step(2);
        chk("R6", "pwr_off held", pwr_off_req, 1);
        pwr_off_done = 1'b1; step(); pwr_off_done = 1'b0;
        chk("R6", "c6 resident", resident, 6);
        chk("R6", "c6 requests", reqs(), 0);
        step(3);
        chk("R6", "c6 stays", resident, 6);
        wake_up();
        chk("R7", "pwr_on_req", pwr_on_req, 1);
        chk("R7", "clk off in pwr_on", clk_en, 0);
        chk("R9", "resident in pwr_on", resident, 6);
        step(2);
        pwr_on_done = 1'b1; step(); pwr_on_done = 1'b0;
        chk("R7", "restore_req", restore_req, 1);
        chk("R7", "clk on in restore", clk_en, 1);
        chk("R9", "resident in restore", resident, 6);
        step(2);
        chk("R7", "restore held", restore_req, 1);
        restore_done = 1'b1; step(); restore_done = 1'b0;
        chk("R7", "active resident", resident, 0);
        chk("R7", "active requests", reqs(), 0);
    endtask

    task automatic t_wake_flush();
        io_req_vld = 1'b1; io_req_lvl = 2'd1; step(); io_req_vld = 1'b0;
        wake_up();
        chk("R8", "flush completes first", flush_req, 1);
        step(2);
        flush_done = 1'b1; step(); flush_done = 1'b0;
        chk("R8", "flush wake resident", resident, 0);
        chk("R8", "flush wake clk", clk_en, 1);
        chk("R8", "flush wake requests", reqs(), 0);
    endtask

    task automatic t_wake_save();
        mw_req_vld = 1'b1; mw_req_hint = 2'd2; step(); mw_req_vld = 1'b0;
        step();
        wake_up();
        chk("R8", "save completes first", save_req, 1);
        save_done = 1'b1; step(); save_done = 1'b0;
        chk("R8", "save wake resident", resident, 0);
        chk("R8", "save wake no pwr_off", pwr_off_req, 0);
        chk("R8", "save wake clk", clk_en, 1);
    endtask

    task automatic t_wake_pwroff();
        mw_req_vld = 1'b1; mw_req_hint = 2'd2; step(); mw_req_vld = 1'b0;
        save_done = 1'b1; step(); save_done = 1'b0;
        wake_up();
        chk("R8", "pwr_off completes", pwr_off_req, 1);
        pwr_off_done = 1'b1; step(); pwr_off_done = 1'b0;
        chk("R8", "reaches c6", resident, 6);
        step();
        chk("R8", "latched wake powers up", pwr_on_req, 1);
        pwr_on_done = 1'b1; step(); pwr_on_done = 1'b0;
        restore_done = 1'b1; step(); restore_done = 1'b0;
        chk("R8", "back to active", resident, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_c1(1'b1);
        t_c1(1'b0);
        t_bad_code();
        t_prio();
        t_c3(1'b1);
        t_c3(1'b0);
        t_c6();
        t_wake_flush();
        t_wake_save();
        t_wake_pwroff();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule